// File: doc/BRIEF.md
# Built-In Self-Test Sequencer

This block runs a self-contained self-test of an internal logic block while the self-test instruction is the current instruction of the test access port. When the controller sits in Run-Test/Idle, the sequencer seeds its own 16-bit pseudo-random pattern generator and clears a 16-bit multiple-input signature register. It then drives generated patterns into the logic under test for a fixed number of sub-tests, each a fixed number of cycles long, and compacts the responses into a signature. When the last sub-test ends, the signature is locked and compared against a stored golden value.

The result is a small serial register of a done flag, a pass bit and the signature. It is loaded by the Capture-DR strobe and shifted out on `tdo` in Shift-DR. No seed and no command is ever shifted in. If the controller leaves Run-Test/Idle before the test ends, the run aborts and the captured result reads as not done. While the instruction is selected, the system input pins are cut off from the logic under test, and the latched values on the system output pins stay frozen.

Top module: `bist_engine`

## Requirements
- R1: Sequencer state and signature advance only on edges where both `bist_sel` and `in_idle` are high. A running test that sees either input low aborts. The next capture then gives an all-zero result (done 0).
- R2: A run starts on an edge in the armed state with `bist_sel` and `in_idle` both high. That edge loads the generator with SEED and clears the signature, so a rerun after an abort reproduces the same signature with nothing shifted in.
- R3: The test runs NSUB sub-tests in order, each CYC cycles long. Sub-test k reseeds the generator with SEED XOR (k*SEED_STEP), truncated to 16 bits. Each cycle the generator steps as a right shift, XORed with TAPS (0xB400) when the bit shifted out was 1. The signature register takes a left shift, XORs in POLY (0x1021) when the old MSB was 1, and XORs in `cut_resp`. The done flag rises 1+NSUB*CYC edges after the start edge is first sampled.
- R4: While a run is in progress, `cut_drive` carries the generator value. At all other times it carries `pin_in`. The signature never depends on `pin_in`.
- R5: When done, the pass bit is 1 exactly when the signature equals GOLDEN.
- R6: An edge with `cap_dr` and `bist_sel` high loads the result register with {done, pass, signature}, or with all zeros when not done. Capture has priority over shift.
- R7: An edge with `shift_dr` and `bist_sel` high (and `cap_dr` low) shifts the 18-bit result register one place toward `tdo`, with `tdi` entering the MSB. The order out is signature bit 0 first, signature bit 15, then pass, then done.
- R8: `pin_out` loads `pre_data` on an `upd_dr` edge only while `bist_sel` is low. It holds its value on every edge while `bist_sel` is high. It resets to 0.
- R9: Once done, the signature and the done flag stay fixed while `bist_sel` is high, even across leaving and re-entering Run-Test/Idle. Dropping `bist_sel` re-arms the sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bist_sel | input | 1 | Self-test instruction is current |
| in_idle | input | 1 | Controller is in Run-Test/Idle |
| cap_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe |
| upd_dr | input | 1 | Update-DR strobe for the output pin latch |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (result register LSB) |
| pin_in | input | 16 | System input pins feeding the logic under test |
| cut_drive | output | 16 | Stimulus to the logic under test |
| cut_resp | input | 16 | Response of the logic under test |
| pre_data | input | 8 | Value for the output pin latch |
| pin_out | output | 8 | Latched system output pins |

## Verification
The signature and done flag are final 1+NSUB*CYC edges after the first sampled edge with both `bist_sel` and `in_idle` high. The bench holds `in_idle` for at least that many edges before it captures, and for fewer edges in abort cases. A capture is visible on `tdo` one edge after `cap_dr`. Each further result bit follows one shift edge later. All inputs are changed, and `tdo` and `pin_out` are sampled, on falling edges, midway between the edges that update them.

// File: rtl/bist_pkg.sv
package bist_pkg;
  localparam int SW = 16;
  typedef logic [SW-1:0] word_t;
  typedef enum logic [1:0] {ST_ARM, ST_RUN, ST_DONE} seq_st_e;

  function automatic word_t prpg_step(word_t v, word_t taps);
    return (v >> 1) ^ (v[0] ? taps : '0);
  endfunction

  function automatic word_t misr_step(word_t m, word_t d, word_t poly);
    return {m[SW-2:0], 1'b0} ^ (m[SW-1] ? poly : '0) ^ d;
  endfunction

  function automatic word_t sub_seed(word_t seed, word_t step, int unsigned k);
    logic [31:0] prod;
    prod = 32'(step) * k;
    return seed ^ prod[SW-1:0];
  endfunction
endpackage

// File: rtl/bist_prpg.sv
module bist_prpg
  import bist_pkg::*;
#(
  parameter word_t TAPS = 16'hB400
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  word_t seed,
  input  logic  adv,
  output word_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= seed;
    else if (adv)  q <= prpg_step(q, TAPS);
  end
endmodule

// File: rtl/bist_misr.sv
module bist_misr
  import bist_pkg::*;
#(
  parameter word_t POLY = 16'h1021
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  en,
  input  word_t d,
  output word_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (en)  q <= misr_step(q, d, POLY);
  end
endmodule

// File: rtl/bist_result_sr.sv
module bist_result_sr #(
  parameter int RW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          cap,
  input  logic          shift,
  input  logic          tdi,
  input  logic [RW-1:0] cap_val,
  output logic          tdo
);
  logic [RW-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              sh <= '0;
    else if (sel && cap)     sh <= cap_val;
    else if (sel && shift)   sh <= {tdi, sh[RW-1:1]};
  end

  assign tdo = sh[0];

  AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && cap) |=> (tdo == $past(cap_val[0]))); // R6
  AST_UNSEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel) |=> $stable(tdo)); // R7
endmodule

// File: rtl/bist_engine.sv
module bist_engine
  import bist_pkg::*;
#(
  parameter word_t       SEED      = 16'hACE1,
  parameter word_t       SEED_STEP = 16'h1111,
  parameter word_t       TAPS      = 16'hB400,
  parameter word_t       POLY      = 16'h1021,
  parameter word_t       GOLDEN    = 16'h0000,
  parameter int unsigned CYC       = 32,
  parameter int unsigned NSUB      = 3,
  parameter int unsigned OW        = 8
) (
  input  logic          tck,
  input  logic          rst_n,
  input  logic          bist_sel,
  input  logic          in_idle,
  input  logic          cap_dr,
  input  logic          shift_dr,
  input  logic          upd_dr,
  input  logic          tdi,
  output logic          tdo,
  input  logic [SW-1:0] pin_in,
  output logic [SW-1:0] cut_drive,
  input  logic [SW-1:0] cut_resp,
  input  logic [OW-1:0] pre_data,
  output logic [OW-1:0] pin_out
);
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
  localparam int NW = (NSUB > 1) ? $clog2(NSUB) : 1;
  localparam int RW = SW + 2;

  seq_st_e          st;
  logic [CW-1:0]    cnt;
  logic [NW-1:0]    sub;
  word_t            lfsr, sig, next_seed;
  logic             go, start, step, abort, sub_end, last_end;
  logic             running, done, pass;
  logic [RW-1:0]    cap_val;

  // named events
  assign go       = bist_sel && in_idle;
  assign running  = (st == ST_RUN);
  assign done     = (st == ST_DONE);
  assign start    = (st == ST_ARM) && go;
  assign step     = running && go;
  assign abort    = running && !go;
  assign sub_end  = step && (cnt == CW'(CYC - 1));
  assign last_end = sub_end && (sub == NW'(NSUB - 1));
  assign next_seed = start ? SEED : sub_seed(SEED, SEED_STEP, 32'(sub) + 1);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_ARM;
      cnt <= '0;
      sub <= '0;
    end else if (!bist_sel) begin
      st  <= ST_ARM;
      cnt <= '0;
      sub <= '0;
    end else begin
      unique case (st)
        ST_ARM: if (start) begin
          st  <= ST_RUN;
          cnt <= '0;
          sub <= '0;
        end
        ST_RUN: begin
          if (abort) begin
            st <= ST_ARM;
          end else if (last_end) begin
            st <= ST_DONE;
          end else if (sub_end) begin
            cnt <= '0;
            sub <= sub + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DONE: st <= ST_DONE;
        default: st <= ST_ARM;
      endcase
    end
  end

  bist_prpg #(.TAPS(TAPS)) u_prpg (
    .clk(tck), .rst_n(rst_n),
    .load(start || (sub_end && !last_end)),
    .seed(next_seed),
    .adv(step && !sub_end),
    .q(lfsr)
  );

  bist_misr #(.POLY(POLY)) u_misr (
    .clk(tck), .rst_n(rst_n),
    .clr(start), .en(step),
    .d(cut_resp), .q(sig)
  );

  assign cut_drive = running ? lfsr : pin_in;
  assign pass      = done && (sig == GOLDEN);
  assign cap_val   = done ? {1'b1, pass, sig} : '0;

  bist_result_sr #(.RW(RW)) u_res (
    .clk(tck), .rst_n(rst_n), .sel(bist_sel),
    .cap(cap_dr), .shift(shift_dr), .tdi(tdi),
    .cap_val(cap_val), .tdo(tdo)
  );

  // output pin latch, frozen while self-test is selected
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                   pin_out <= '0;
    else if (upd_dr && !bist_sel) pin_out <= pre_data;
  end

  AST_IDLE_ONLY: assert property (@(posedge tck) disable iff (!rst_n)
    (!in_idle) |=> $stable(sig)); // R1
  AST_ABORT_CLEAR: assert property (@(posedge tck) disable iff (!rst_n)
    (running && !in_idle) |=> !done); // R1
  AST_SEED_LOAD: assert property (@(posedge tck) disable iff (!rst_n)
    start |=> (lfsr == SEED && sig == '0)); // R2
  AST_CNT_RANGE: assert property (@(posedge tck) disable iff (!rst_n)
    running |-> (cnt <= CW'(CYC - 1))); // R3
  AST_PIN_HOLD: assert property (@(posedge tck) disable iff (!rst_n)
    bist_sel |=> $stable(pin_out)); // R8
  AST_DONE_LOCK: assert property (@(posedge tck) disable iff (!rst_n)
    (done && bist_sel) |=> (done && $stable(sig))); // R9
endmodule

// File: tb/sim_bist_engine.sv
`timescale 1ns/1ps
module sim_bist_engine;
  localparam logic [15:0] SEED  = 16'hACE1;
  localparam logic [15:0] STEPV = 16'h1111;
  localparam logic [15:0] TAPS  = 16'hB400;
  localparam logic [15:0] POLY  = 16'h1021;
  localparam int CYC  = 32;
  localparam int NSUB = 3;
  localparam int FULL = 1 + NSUB * CYC;

  function automatic logic [15:0] cut_fn(logic [15:0] x, bit flt);
    return {x[12:0], x[15:13]} ^ (x & {x[0], x[15:1]}) ^ {15'd0, flt};
  endfunction

  function automatic logic [15:0] exp_sig(bit flt);
    logic [15:0] l, m, r, nl;
    logic [31:0] p;
    m = 16'd0;
    for (int k = 0; k < NSUB; k++) begin
      p = STEPV * k;
      l = SEED ^ p[15:0];
      for (int i = 0; i < CYC; i++) begin
        r = cut_fn(l, flt);
        m = m[15] ? (({m[14:0], 1'b0} ^ POLY) ^ r) : ({m[14:0], 1'b0} ^ r);
        nl = {1'b0, l[15:1]};
        if (l[0]) nl = nl ^ TAPS;
        l = nl;
      end
    end
    return m;
  endfunction

  localparam logic [15:0] GOLD = exp_sig(1'b0);

  logic tck = 0, rst_n = 0, bist_sel = 0, in_idle = 0;
  logic cap_dr = 0, shift_dr = 0, upd_dr = 0, tdi = 0, fault = 0;
  logic tdo;
  logic [15:0] pin_in = 0, cut_drive, cut_resp;
  logic [7:0] pre_data = 0, pin_out;
  int n_chk = 0, n_err = 0;
  logic [17:0] got;
  logic [7:0] pin_ref;

  always #2 tck = ~tck;
  assign cut_resp = cut_fn(cut_drive, fault);

  bist_engine #(.SEED(SEED), .SEED_STEP(STEPV), .TAPS(TAPS), .POLY(POLY),
                .GOLDEN(GOLD), .CYC(CYC), .NSUB(NSUB), .OW(8)) u0 (
    .tck(tck), .rst_n(rst_n), .bist_sel(bist_sel), .in_idle(in_idle),
    .cap_dr(cap_dr), .shift_dr(shift_dr), .upd_dr(upd_dr), .tdi(tdi),
    .tdo(tdo), .pin_in(pin_in), .cut_drive(cut_drive), .cut_resp(cut_resp),
    .pre_data(pre_data), .pin_out(pin_out));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hold_idle(int n);
    in_idle = 1;
    repeat (n) begin
      pin_in = 16'($urandom);
      upd_dr = 1'($urandom);
      pre_data = 8'($urandom);
      @(negedge tck);
    end
    in_idle = 0;
    upd_dr = 0;
    @(negedge tck);
  endtask

  task automatic read_res(input logic [17:0] fill, input bit do_cap, output logic [17:0] r);
    if (do_cap) begin
      cap_dr = 1;
      @(negedge tck);
      cap_dr = 0;
    end
    shift_dr = 1;
    for (int i = 0; i < 18; i++) begin
      r[i] = tdo;
      tdi = fill[i];
      @(negedge tck);
    end
    shift_dr = 0;
  endtask

  task automatic rearm();
    bist_sel = 0;
    @(negedge tck);
    bist_sel = 1;
    @(negedge tck);
  endtask

  initial begin
    #800000;
    n_err++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [17:0] fillw;
    logic [15:0] fsig;
    void'($urandom(32'd1234));
    pin_in = 16'h5A5A;
    repeat (3) @(negedge tck);
    rst_n = 1;
    @(negedge tck);
    // reset state
    check("R8 reset pin_out", 32'(pin_out), 0);
    check("R4 idle passthrough", 32'(cut_drive), 32'h5A5A);
    // R8 load while not selected
    pre_data = 8'hC3; upd_dr = 1;
    @(negedge tck);
    upd_dr = 0;
    check("R8 preload", 32'(pin_out), 32'hC3);
    pin_ref = 8'hC3;
    // capture before any run: not done
    bist_sel = 1;
    @(negedge tck);
    read_res(18'h0, 1, got);
    check("R6 capture not done", 32'(got), 0);
    // full run with random pin_in and update attempts
    hold_idle(FULL + 3);
    check("R8 pins frozen", 32'(pin_out), 32'(pin_ref));
    read_res(18'h2A5C3, 1, got);
    check("R5 done flag", 32'(got[17]), 1);
    check("R5 pass bit", 32'(got[16]), 1);
    check("R3 signature", 32'(got[15:0]), 32'(GOLD));
    read_res(18'h0, 0, got);
    check("R7 tdi shift path", 32'(got), 32'h2A5C3);
    // R9 rerun attempt without dropping sel
    hold_idle(20);
    read_res(18'h0, 1, got);
    check("R9 locked result", 32'(got), 32'({2'b11, GOLD}));
    // R1 abort
    rearm();
    hold_idle(40);
    read_res(18'h0, 1, got);
    check("R1 abort not done", 32'(got), 0);
    // R1 abort by one short of completion
    rearm();
    hold_idle(FULL - 1);
    read_res(18'h0, 1, got);
    check("R1 abort at last edge", 32'(got), 0);
    // R2 rerun after abort
    rearm();
    hold_idle(FULL);
    read_res(18'h0, 1, got);
    check("R2 rerun signature", 32'(got), 32'({2'b11, GOLD}));
    // R5 faulty logic
    rearm();
    fault = 1;
    hold_idle(FULL + 1);
    fault = 0;
    fsig = exp_sig(1'b1);
    read_res(18'h0, 1, got);
    check("R5 fault pass bit", 32'(got[17:16]), 32'h2);
    check("R3 fault signature", 32'(got[15:0]), 32'(fsig));
    // R6 capture priority over shift
    fillw = 18'h3FFFF;
    cap_dr = 1; shift_dr = 1;
    @(negedge tck);
    cap_dr = 0; shift_dr = 0;
    check("R6 capture priority", 32'(tdo), 32'(fsig[0]));
    // random runs: abort or full
    for (int it = 0; it < 8; it++) begin
      int n;
      rearm();
      n = (($urandom % 2) == 0) ? 1 + int'($urandom % (FULL - 1)) : FULL + int'($urandom % 4);
      hold_idle(n);
      read_res(18'h0, 1, got);
      if (n >= FULL) check("R4 random full run", 32'(got), 32'({2'b11, GOLD}));
      else           check("R1 random abort", 32'(got), 0);
    end
    // R8 update works again after deselect
    bist_sel = 0; pre_data = 8'h3C; upd_dr = 1;
    @(negedge tck);
    upd_dr = 0;
    check("R8 reload after deselect", 32'(pin_out), 32'h3C);
    check("R4 passthrough after test", 32'(cut_drive), 32'(pin_in));
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule